// File: doc/BRIEF.md
# Auxiliary Audio Memory Block Mover

This engine copies blocks of data between main memory and a secondary audio memory, in either direction. Software first sets a main-memory byte address, an audio-memory byte address, and a length word through a small 16-bit register window. The length word also carries the transfer direction. Writing the lower half of the length word launches the copy.

The engine moves one 64-bit beat at a time through two synchronous single-port memory interfaces, each with a read latency of one cycle. Each beat is byte-reversed on the way through. While a copy runs, `busy` is high. A single-cycle `done_irq` pulse marks the end of the copy.

At launch, both addresses are folded into a 64 MB window. The engine treats audio addresses at or beyond the installed size in a special way. Reads from that region give zeros to main memory. Writes to that region are skipped, but the addresses and the length still move as if the data had been written. An optional map mode stores each beat bound for the lower audio bank a second time, in the upper bank.

Top module: `auxdma_engine`

## Requirements
- R1: After reset, `busy` and `done_irq` are low, no memory port is enabled, and every register reads back as zero.
- R2: The register window uses `reg_sel` codes 0/1 for the main address high/low halves, 2/3 for the audio address high/low halves, 4/5 for the length high/low halves, and 6 for the map mode (bits 3:0). Writes to codes 1, 3 and 5 have bits 4:0 cleared.
- R3: A write to code 5 launches a copy. `busy` is high from the next cycle until the copy ends.
- R4: Bit 15 of the length high half selects the direction: 0 copies main to audio, 1 copies audio to main. The length is the remaining 31 bits, in bytes. Each 64-bit beat is stored with its byte order reversed, so byte 0 goes to byte 7.
- R5: An in-range beat takes two cycles: a read, then a write. After each beat, both addresses grow by 8 and the length drops by 8. At the end, the length reads zero and both addresses have grown by the original length.
- R6: On launch, both addresses are reduced to their low 26 bits. Read-back shows the reduced values.
- R7: For an audio-to-main copy whose audio start address is at or beyond `AUX_BYTES`, the engine writes zeros to main memory. Each such beat takes one cycle, and the audio port is never touched.
- R8: For a main-to-audio copy whose audio start address is at or beyond `AUX_BYTES`, neither memory is accessed. Both addresses grow by the length, the length is cleared, and `busy` lasts one cycle.
- R9: With map mode 4, a main-to-audio beat whose audio address is below `BANK_OFFSET` is also written at that address plus `BANK_OFFSET`, in a third cycle. At or above `BANK_OFFSET`, no second write happens.
- R10: `done_irq` is a one-cycle pulse. It rises in the same cycle that `busy` falls. A zero length gives one busy cycle and then the pulse.
- R11: Register writes are ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select, used for both write and read |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read-back of the selected register |
| busy | output | 1 | Copy in progress |
| done_irq | output | 1 | Single-cycle completion pulse |
| mm_en | output | 1 | Main memory access enable |
| mm_we | output | 1 | Main memory write enable |
| mm_addr | output | 26 | Main memory byte address |
| mm_wdata | output | 64 | Main memory write beat |
| mm_rdata | input | 64 | Main memory read beat, valid one cycle after a read |
| ax_en | output | 1 | Audio memory access enable |
| ax_we | output | 1 | Audio memory write enable |
| ax_addr | output | 24 | Audio memory byte address |
| ax_wdata | output | 64 | Audio memory write beat |
| ax_rdata | input | 64 | Audio memory read beat, valid one cycle after a read |

## Verification
A wrong sequencer state shows up at once as a change in how long `busy` stays high. It also shows up as the `done_irq` pulse landing in the wrong cycle. Because of this, the bench predicts the exact busy length for each kind of copy and compares `busy` and `done_irq` on every clock.

Errors in the address or length counters remain hidden until the copy ends. They then appear in the register read-back and in which memory words were touched. The bench therefore checks read-back and memory contents right after each completion pulse. It also counts audio-port writes, which exposes skipped or duplicated beats.

// File: rtl/auxdma_pkg.sv
package auxdma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_COPY2 = 2'd3
  } dma_state_t;

  localparam logic [2:0] SEL_MAIN_HI = 3'd0;
  localparam logic [2:0] SEL_MAIN_LO = 3'd1;
  localparam logic [2:0] SEL_AUX_HI  = 3'd2;
  localparam logic [2:0] SEL_AUX_LO  = 3'd3;
  localparam logic [2:0] SEL_LEN_HI  = 3'd4;
  localparam logic [2:0] SEL_LEN_LO  = 3'd5;
  localparam logic [2:0] SEL_MODE    = 3'd6;

  localparam logic [15:0] LOW_ALIGN_MASK = 16'hFFE0;
  localparam int          BEAT_BYTES     = 8;
  localparam int          BEAT_BITS      = BEAT_BYTES * 8;
  localparam logic [3:0]  DUP_MAP_MODE   = 4'd4;

  function automatic logic [BEAT_BITS-1:0] swap_beat(input logic [BEAT_BITS-1:0] d);
    logic [BEAT_BITS-1:0] r;
    for (int i = 0; i < BEAT_BYTES; i++) begin
      r[8*i +: 8] = d[8*(BEAT_BYTES-1-i) +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/auxdma_regs.sv
module auxdma_regs
  import auxdma_pkg::*;
#(
  parameter int WRAP_BITS = 26
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [2:0]  wr_sel,
  input  logic [15:0] wr_data,
  input  logic [2:0]  rd_sel,
  output logic [15:0] rd_data,
  input  logic        busy,
  input  logic        adv_beat,
  input  logic        adv_skip,
  output logic [31:0] main_addr,
  output logic [31:0] aux_addr,
  output logic [30:0] xfer_len,
  output logic        xfer_dir,
  output logic [3:0]  map_mode,
  output logic        start
);

  localparam logic [31:0] WRAP_MASK = 32'((64'd1 << WRAP_BITS) - 64'd1);
  localparam logic [31:0] STEP      = 32'(BEAT_BYTES);

  logic [31:0] main_q, aux_q;
  logic [15:0] len_hi_q, len_lo_q;
  logic [3:0]  mode_q;
  logic        start_q;

  assign xfer_len  = {len_hi_q[14:0], len_lo_q};
  assign xfer_dir  = len_hi_q[15];
  assign main_addr = main_q;
  assign aux_addr  = aux_q;
  assign map_mode  = mode_q;
  assign start     = start_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      main_q   <= '0;
      aux_q    <= '0;
      len_hi_q <= '0;
      len_lo_q <= '0;
      mode_q   <= '0;
      start_q  <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (wr_en && !busy) begin
        case (wr_sel)
          SEL_MAIN_HI: main_q[31:16] <= wr_data;
          SEL_MAIN_LO: main_q[15:0]  <= wr_data & LOW_ALIGN_MASK;
          SEL_AUX_HI:  aux_q[31:16]  <= wr_data;
          SEL_AUX_LO:  aux_q[15:0]   <= wr_data & LOW_ALIGN_MASK;
          SEL_LEN_HI:  len_hi_q      <= wr_data;
          SEL_LEN_LO: begin
            len_lo_q <= wr_data & LOW_ALIGN_MASK;
            main_q   <= main_q & WRAP_MASK;
            aux_q    <= aux_q & WRAP_MASK;
            start_q  <= 1'b1;
          end
          SEL_MODE:    mode_q <= wr_data[3:0];
          default: ;
        endcase
      end else if (adv_beat) begin
        main_q <= main_q + STEP;
        aux_q  <= aux_q + STEP;
        {len_hi_q[14:0], len_lo_q} <= xfer_len - 31'(BEAT_BYTES);
      end else if (adv_skip) begin
        main_q <= main_q + {1'b0, xfer_len};
        aux_q  <= aux_q + {1'b0, xfer_len};
        {len_hi_q[14:0], len_lo_q} <= '0;
      end
    end
  end

  always_comb begin
    case (rd_sel)
      SEL_MAIN_HI: rd_data = main_q[31:16];
      SEL_MAIN_LO: rd_data = main_q[15:0];
      SEL_AUX_HI:  rd_data = aux_q[31:16];
      SEL_AUX_LO:  rd_data = aux_q[15:0];
      SEL_LEN_HI:  rd_data = len_hi_q;
      SEL_LEN_LO:  rd_data = len_lo_q;
      SEL_MODE:    rd_data = {12'd0, mode_q};
      default:     rd_data = 16'd0;
    endcase
  end

  // R11
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_en) |=> $stable(mode_q));

  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    adv_beat |-> (xfer_len >= 31'(BEAT_BYTES)));

endmodule

// File: rtl/auxdma_span.sv
module auxdma_span
  import auxdma_pkg::*;
#(
  parameter int unsigned WRAP_BITS   = 26,
  parameter int unsigned AUX_BYTES   = 32'h0100_0000,
  parameter int unsigned BANK_OFFSET = 32'h0040_0000,
  localparam int AUX_AW = $clog2(AUX_BYTES)
) (
  input  logic [31:0]          main_addr,
  input  logic [31:0]          aux_addr,
  input  logic                 xfer_dir,
  input  logic [3:0]           map_mode,
  output logic [WRAP_BITS-1:0] main_port,
  output logic [AUX_AW-1:0]    aux_port,
  output logic [AUX_AW-1:0]    aux_dup,
  output logic                 beyond,
  output logic                 dup_needed
);

  assign main_port = main_addr[WRAP_BITS-1:0];
  assign aux_port  = aux_addr[AUX_AW-1:0];
  assign beyond    = ({1'b0, aux_addr} >= 33'(AUX_BYTES));

  generate
    if (BANK_OFFSET < AUX_BYTES) begin : g_dup
      assign aux_dup    = aux_port + AUX_AW'(BANK_OFFSET);
      assign dup_needed = (map_mode == DUP_MAP_MODE) && !xfer_dir &&
                          ({1'b0, aux_addr} < 33'(BANK_OFFSET));
    end else begin : g_nodup
      assign aux_dup    = aux_port;
      assign dup_needed = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/auxdma_seq.sv
module auxdma_seq
  import auxdma_pkg::*;
#(
  parameter int MAIN_AW = 26,
  parameter int AUX_AW  = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [30:0]          xfer_len,
  input  logic                 xfer_dir,
  input  logic                 beyond,
  input  logic                 dup_needed,
  input  logic [MAIN_AW-1:0]   main_port,
  input  logic [AUX_AW-1:0]    aux_port,
  input  logic [AUX_AW-1:0]    aux_dup,
  output logic                 mm_en,
  output logic                 mm_we,
  output logic [MAIN_AW-1:0]   mm_addr,
  output logic [BEAT_BITS-1:0] mm_wdata,
  input  logic [BEAT_BITS-1:0] mm_rdata,
  output logic                 ax_en,
  output logic                 ax_we,
  output logic [AUX_AW-1:0]    ax_addr,
  output logic [BEAT_BITS-1:0] ax_wdata,
  input  logic [BEAT_BITS-1:0] ax_rdata,
  output logic                 adv_beat,
  output logic                 adv_skip,
  output logic                 active,
  output logic                 done_irq
);

  dma_state_t state_q, state_d;
  logic                 zero_fill_q;
  logic [BEAT_BITS-1:0] beat_q;
  logic                 irq_q, irq_d;
  logic                 last_beat;

  assign last_beat = (xfer_len == 31'(BEAT_BYTES));
  assign active    = (state_q != ST_IDLE);
  assign done_irq  = irq_q;

  always_comb begin
    state_d  = state_q;
    irq_d    = 1'b0;
    adv_beat = 1'b0;
    adv_skip = 1'b0;
    mm_en    = 1'b0;
    mm_we    = 1'b0;
    mm_addr  = main_port;
    mm_wdata = '0;
    ax_en    = 1'b0;
    ax_we    = 1'b0;
    ax_addr  = aux_port;
    ax_wdata = '0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (xfer_len == '0) begin
            irq_d = 1'b1;
          end else if (beyond && !xfer_dir) begin
            adv_skip = 1'b1;
            irq_d    = 1'b1;
          end else if (beyond) begin
            state_d = ST_WRITE;
          end else begin
            state_d = ST_READ;
          end
        end
      end
      ST_READ: begin
        if (xfer_dir) ax_en = 1'b1;
        else          mm_en = 1'b1;
        state_d = ST_WRITE;
      end
      ST_WRITE: begin
        if (xfer_dir) begin
          mm_en    = 1'b1;
          mm_we    = 1'b1;
          mm_wdata = zero_fill_q ? '0 : swap_beat(ax_rdata);
        end else begin
          ax_en    = 1'b1;
          ax_we    = 1'b1;
          ax_wdata = swap_beat(mm_rdata);
        end
        if (!xfer_dir && dup_needed) begin
          state_d = ST_COPY2;
        end else begin
          adv_beat = 1'b1;
          irq_d    = last_beat;
          state_d  = last_beat ? ST_IDLE : (zero_fill_q ? ST_WRITE : ST_READ);
        end
      end
      ST_COPY2: begin
        ax_en    = 1'b1;
        ax_we    = 1'b1;
        ax_addr  = aux_dup;
        ax_wdata = beat_q;
        adv_beat = 1'b1;
        irq_d    = last_beat;
        state_d  = last_beat ? ST_IDLE : ST_READ;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      zero_fill_q <= 1'b0;
      beat_q      <= '0;
      irq_q       <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= irq_d;
      if (start) zero_fill_q <= beyond && xfer_dir;
      if (state_q == ST_WRITE) beat_q <= swap_beat(mm_rdata);
    end
  end

  // R7
  fill_no_aux_chk: assert property (@(posedge clk) disable iff (rst)
    (active && zero_fill_q) |-> !ax_en);

  // R9
  copy2_order_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_COPY2) |-> ($past(state_q) == ST_WRITE));

endmodule

// File: rtl/auxdma_engine.sv
module auxdma_engine
  import auxdma_pkg::*;
#(
  parameter int unsigned WRAP_BITS   = 26,
  parameter int unsigned AUX_BYTES   = 32'h0100_0000,
  parameter int unsigned BANK_OFFSET = 32'h0040_0000,
  localparam int AUX_AW = $clog2(AUX_BYTES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_we,
  input  logic [2:0]           reg_sel,
  input  logic [15:0]          reg_wdata,
  output logic [15:0]          reg_rdata,
  output logic                 busy,
  output logic                 done_irq,
  output logic                 mm_en,
  output logic                 mm_we,
  output logic [WRAP_BITS-1:0] mm_addr,
  output logic [63:0]          mm_wdata,
  input  logic [63:0]          mm_rdata,
  output logic                 ax_en,
  output logic                 ax_we,
  output logic [AUX_AW-1:0]    ax_addr,
  output logic [63:0]          ax_wdata,
  input  logic [63:0]          ax_rdata
);

  logic [31:0]          main_addr, aux_addr;
  logic [30:0]          xfer_len;
  logic                 xfer_dir, start, adv_beat, adv_skip, active;
  logic [3:0]           map_mode;
  logic [WRAP_BITS-1:0] main_port;
  logic [AUX_AW-1:0]    aux_port, aux_dup;
  logic                 beyond, dup_needed;

  assign busy = start | active;

  auxdma_regs #(.WRAP_BITS(WRAP_BITS)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(reg_we), .wr_sel(reg_sel), .wr_data(reg_wdata),
    .rd_sel(reg_sel), .rd_data(reg_rdata),
    .busy(busy), .adv_beat(adv_beat), .adv_skip(adv_skip),
    .main_addr(main_addr), .aux_addr(aux_addr),
    .xfer_len(xfer_len), .xfer_dir(xfer_dir),
    .map_mode(map_mode), .start(start)
  );

  auxdma_span #(
    .WRAP_BITS(WRAP_BITS), .AUX_BYTES(AUX_BYTES), .BANK_OFFSET(BANK_OFFSET)
  ) u_span (
    .main_addr(main_addr), .aux_addr(aux_addr),
    .xfer_dir(xfer_dir), .map_mode(map_mode),
    .main_port(main_port), .aux_port(aux_port), .aux_dup(aux_dup),
    .beyond(beyond), .dup_needed(dup_needed)
  );

  auxdma_seq #(.MAIN_AW(WRAP_BITS), .AUX_AW(AUX_AW)) u_seq (
    .clk(clk), .rst(rst), .start(start),
    .xfer_len(xfer_len), .xfer_dir(xfer_dir),
    .beyond(beyond), .dup_needed(dup_needed),
    .main_port(main_port), .aux_port(aux_port), .aux_dup(aux_dup),
    .mm_en(mm_en), .mm_we(mm_we), .mm_addr(mm_addr),
    .mm_wdata(mm_wdata), .mm_rdata(mm_rdata),
    .ax_en(ax_en), .ax_we(ax_we), .ax_addr(ax_addr),
    .ax_wdata(ax_wdata), .ax_rdata(ax_rdata),
    .adv_beat(adv_beat), .adv_skip(adv_skip),
    .active(active), .done_irq(done_irq)
  );

  // R10
  irq_busy_low_chk: assert property (@(posedge clk) disable iff (rst)
    done_irq |-> !busy);

  // R10
  irq_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_irq |=> !done_irq);

  // R10
  irq_follows_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done_irq |-> $past(busy));

  // R4
  aux_write_dir_chk: assert property (@(posedge clk) disable iff (rst)
    (ax_en && ax_we) |-> !xfer_dir);

  // R4
  main_write_dir_chk: assert property (@(posedge clk) disable iff (rst)
    (mm_en && mm_we) |-> xfer_dir);

endmodule

// File: tb/sim_auxdma_engine.sv
`timescale 1ns/1ps
module sim_auxdma_engine;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        busy, done_irq;
  logic        mm_en, mm_we, ax_en, ax_we;
  logic [25:0] mm_addr;
  logic [23:0] ax_addr;
  logic [63:0] mm_wdata, ax_wdata;
  logic [63:0] mm_rdata = 64'd0;
  logic [63:0] ax_rdata = 64'd0;

  int checks = 0;
  int fails  = 0;
  int ax_writes = 0;
  int mm_accesses = 0;
  int ax_accesses = 0;

  bit [63:0] mmem [int];
  bit [63:0] amem [int];

  always #2 clk = ~clk;

  auxdma_engine u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy), .done_irq(done_irq),
    .mm_en(mm_en), .mm_we(mm_we), .mm_addr(mm_addr),
    .mm_wdata(mm_wdata), .mm_rdata(mm_rdata),
    .ax_en(ax_en), .ax_we(ax_we), .ax_addr(ax_addr),
    .ax_wdata(ax_wdata), .ax_rdata(ax_rdata)
  );

  function automatic bit [63:0] rev8(input bit [63:0] d);
    bit [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = d[8*(7-i) +: 8];
    return r;
  endfunction

  function automatic bit [63:0] pat(input int a, input int salt);
    return {32'(a) ^ 32'(salt), 32'(a) * 32'd2654435 + 32'h0102_0304};
  endfunction

  function automatic bit [63:0] mget(input int a);
    return mmem.exists(a) ? mmem[a] : 64'd0;
  endfunction

  function automatic bit [63:0] aget(input int a);
    return amem.exists(a) ? amem[a] : 64'd0;
  endfunction

  always @(posedge clk) begin
    if (mm_en) begin
      mm_accesses++;
      if (mm_we) mmem[int'(mm_addr)] = mm_wdata;
      else mm_rdata <= mget(int'(mm_addr));
    end
    if (ax_en) begin
      ax_accesses++;
      if (ax_we) begin
        amem[int'(ax_addr)] = ax_wdata;
        ax_writes++;
      end else ax_rdata <= aget(int'(ax_addr));
    end
  end

  task automatic check(input string req, input bit [63:0] act, input bit [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input bit [2:0] sel, input bit [15:0] val);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input bit [2:0] sel, output bit [15:0] val);
    reg_sel = sel;
    #1;
    val = reg_rdata;
  endtask

  task automatic rdchk(input string req, input bit [2:0] sel, input bit [15:0] exp);
    bit [15:0] v;
    rd(sel, v);
    check(req, 64'(v), 64'(exp));
  endtask

  // Program and launch; compare busy and done_irq on every clock.
  task automatic run_xfer(input bit [31:0] mma, input bit [31:0] axa,
                          input bit [15:0] hi, input bit [15:0] lo,
                          input int exp_busy, input string req);
    wr(3'd0, mma[31:16]); wr(3'd1, mma[15:0]);
    wr(3'd2, axa[31:16]); wr(3'd3, axa[15:0]);
    wr(3'd4, hi);
    wr(3'd5, lo);
    for (int c = 0; c < exp_busy; c++) begin
      check({req, " busy"}, 64'(busy), 64'd1);
      check({req, " R10 no early irq"}, 64'(done_irq), 64'd0);
      @(negedge clk);
    end
    check({req, " R10 busy falls"}, 64'(busy), 64'd0);
    check({req, " R10 irq pulse"}, 64'(done_irq), 64'd1);
    @(negedge clk);
    check({req, " R10 irq one cycle"}, 64'(done_irq), 64'd0);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int base_w;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 busy", 64'(busy), 64'd0);
    check("R1 irq", 64'(done_irq), 64'd0);
    check("R1 ports", 64'({mm_en, ax_en}), 64'd0);
    for (int s = 0; s < 7; s++) rdchk("R1 readback", 3'(s), 16'd0);

    // R2 low halves drop bits 4:0
    wr(3'd1, 16'h123F);
    rdchk("R2 main lo mask", 3'd1, 16'h1220);
    wr(3'd3, 16'hABCD);
    rdchk("R2 aux lo mask", 3'd3, 16'hABC0);
    wr(3'd0, 16'h5A5A);
    rdchk("R2 main hi full", 3'd0, 16'h5A5A);

    // R3 R4 R5 main -> audio, 64 bytes, 2 cycles per beat
    for (int i = 0; i < 8; i++) mmem[32'h100 + 8*i] = pat(32'h100 + 8*i, 1);
    base_w = ax_writes;
    run_xfer(32'h0000_0100, 32'h0000_0200, 16'h0000, 16'h0040, 1 + 8*2, "R3 R5");
    for (int i = 0; i < 8; i++)
      check("R4 aux data swapped", aget(32'h200 + 8*i), rev8(pat(32'h100 + 8*i, 1)));
    check("R5 aux write count", 64'(ax_writes - base_w), 64'd8);
    rdchk("R5 main lo advanced", 3'd1, 16'h0140);
    rdchk("R5 aux lo advanced", 3'd3, 16'h0240);
    rdchk("R5 length cleared", 3'd5, 16'h0000);
    rdchk("R5 length hi", 3'd4, 16'h0000);

    // R4 R6 R2 audio -> main with mirrored main address and ragged length
    for (int i = 0; i < 4; i++) amem[32'h300 + 8*i] = pat(32'h300 + 8*i, 2);
    run_xfer(32'h0400_0800, 32'h0000_0300, 16'h8000, 16'h002F, 1 + 4*2, "R4 R6");
    for (int i = 0; i < 4; i++)
      check("R4 main data swapped", mget(32'h800 + 8*i), rev8(pat(32'h300 + 8*i, 2)));
    rdchk("R6 main hi wrapped", 3'd0, 16'h0000);
    rdchk("R6 main lo", 3'd1, 16'h0820);
    rdchk("R4 dir kept", 3'd4, 16'h8000);
    rdchk("R2 length lo", 3'd5, 16'h0000);

    // R7 audio beyond size -> zeros into main
    for (int i = 0; i < 4; i++) mmem[32'hA00 + 8*i] = 64'hFFFF_FFFF_FFFF_FFFF;
    base_w = ax_accesses;
    run_xfer(32'h0000_0A00, 32'h0100_0000, 16'h8000, 16'h0020, 1 + 4, "R7");
    for (int i = 0; i < 4; i++)
      check("R7 main zeroed", mget(32'hA00 + 8*i), 64'd0);
    check("R7 audio untouched", 64'(ax_accesses - base_w), 64'd0);

    // R8 main -> audio beyond size: skipped
    base_w = ax_accesses + mm_accesses;
    run_xfer(32'h0000_0C00, 32'h0200_0040, 16'h0000, 16'h0060, 1, "R8");
    check("R8 no accesses", 64'(ax_accesses + mm_accesses - base_w), 64'd0);
    rdchk("R8 aux hi", 3'd2, 16'h0200);
    rdchk("R8 aux lo", 3'd3, 16'h00A0);
    rdchk("R8 main lo", 3'd1, 16'h0C60);
    rdchk("R8 length cleared", 3'd5, 16'h0000);

    // R9 map mode 4: lower bank mirrored into upper bank
    wr(3'd6, 16'h0004);
    rdchk("R2 mode", 3'd6, 16'h0004);
    for (int i = 0; i < 4; i++) mmem[32'hE00 + 8*i] = pat(32'hE00 + 8*i, 3);
    base_w = ax_writes;
    run_xfer(32'h0000_0E00, 32'h0000_1000, 16'h0000, 16'h0020, 1 + 4*3, "R9 low");
    for (int i = 0; i < 4; i++) begin
      check("R9 primary", aget(32'h1000 + 8*i), rev8(pat(32'hE00 + 8*i, 3)));
      check("R9 duplicate", aget(32'h401000 + 8*i), rev8(pat(32'hE00 + 8*i, 3)));
    end
    check("R9 write count low", 64'(ax_writes - base_w), 64'd8);
    base_w = ax_writes;
    run_xfer(32'h0000_0E00, 32'h0041_0000, 16'h0000, 16'h0020, 1 + 4*2, "R9 high");
    check("R9 write count high", 64'(ax_writes - base_w), 64'd4);
    check("R9 no upper copy", 64'(amem.exists(32'h810000)), 64'd0);
    check("R9 upper data", aget(32'h410000), rev8(pat(32'hE00, 3)));

    // R10 zero length
    run_xfer(32'h0000_0000, 32'h0000_0000, 16'h0000, 16'h001F, 1, "R10 zero");

    // R11 writes while busy are ignored
    wr(3'd0, 16'h0000); wr(3'd1, 16'h0100);
    wr(3'd2, 16'h0000); wr(3'd3, 16'h0600);
    wr(3'd4, 16'h0000); wr(3'd5, 16'h0040);
    check("R3 busy after launch", 64'(busy), 64'd1);
    wr(3'd0, 16'h1234);
    wr(3'd6, 16'h0007);
    for (int c = 0; c < 100 && !done_irq; c++) @(negedge clk);
    check("R11 completion seen", 64'(done_irq), 64'd1);
    @(negedge clk);
    rdchk("R11 main hi kept", 3'd0, 16'h0000);
    rdchk("R11 mode kept", 3'd6, 16'h0004);
    rdchk("R11 main lo", 3'd1, 16'h0140);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule